// File: doc/BRIEF.md
# Conversion Flag and Interrupt Controller

This block keeps the per-slot completion flags and the sequence-complete flag for a multi-slot analog-to-digital conversion sequencer. It also raises the two level interrupt requests that are derived from those flags. The converter side reports three events as single-cycle pulses: a slot finished (with its index), whether that slot's automatic compare succeeded, and the end of the whole sequence. The bus side holds a three-bit control register and a per-slot compare-enable register. It can clear flags by writing ones, and it sends read and write strobes for the result registers together with a slot index.

The block has two clear modes. In normal mode a slot flag is cleared only by a write-one-to-clear. In fast mode that write has no effect. Instead, accessing a slot's result register clears that slot's flag. The kind of access that clears depends on the slot's compare enable: a read clears it when compare is off, and a write clears it when compare is on. A small state machine follows the sequence through three states, IDLE, RUN and HALT. Any control-register write aborts a running sequence. That write also produces a one-cycle abort pulse.

Top module: `cfic_top`

## Requirements
- R1: The control register holds fast-clear in bit 2, the sequence interrupt enable in bit 1 and the compare interrupt enable in bit 0. It resets to 0, can be written in any cycle, and reads back on `ctrl_rdata` from the cycle after the write.
- R2: Every `ctrl_wr` makes `abort_o` high for exactly the following cycle. If the state machine is in RUN, it moves to HALT, so `seq_busy` is low in the following cycle. Converter pulses that arrive in the same cycle as the write are dropped.
- R3: A `slot_done` pulse in RUN sets flag `slot_idx` in the next cycle. When compare is disabled for that slot the flag always sets. When compare is enabled, the flag sets only if `cmp_hit` is 1.
- R4: With fast-clear at 0, `flag_clr_wr` clears every flag whose bit in `flag_clr_data` is 1. Result-register reads and writes leave the flags unchanged.
- R5: With fast-clear at 1 and compare disabled for slot `res_idx`, `res_rd` clears that slot's flag. `res_wr` and `flag_clr_wr` leave it unchanged.
- R6: With fast-clear at 1 and compare enabled for slot `res_idx`, `res_wr` clears that slot's flag. `res_rd` and `flag_clr_wr` leave it unchanged.
- R7: When a set and a clear hit the same slot in the same cycle, the flag ends up at 1.
- R8: A `seq_done` in RUN sets `seq_flag` and returns to IDLE. A `seq_clr_wr` clears `seq_flag`. A `seq_start` in HALT (relaunch) clears it. A `seq_start` in IDLE (launch) keeps it.
- R9: `seq_irq` is 1 exactly when `seq_flag` is 1 and the sequence interrupt enable is 1.
- R10: `cmp_irq` is 1 exactly when the compare interrupt enable is 1 and some slot has both its flag and its compare enable at 1.
- R11: `slot_done` and `seq_done` pulses that arrive in IDLE or HALT change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data {fast, seq_ie, cmp_ie} |
| ctrl_rdata | output | 3 | Control register contents |
| cmpen_wr | input | 1 | Compare-enable register write strobe |
| cmpen_wdata | input | NSLOT | Compare-enable write data, one bit per slot |
| cmpen_rdata | output | NSLOT | Compare-enable register contents |
| flag_clr_wr | input | 1 | Write-one-to-clear strobe for the slot flags |
| flag_clr_data | input | NSLOT | Slot flags to clear |
| seq_clr_wr | input | 1 | Write-one-to-clear strobe for the sequence flag |
| res_rd | input | 1 | Result register read strobe |
| res_wr | input | 1 | Result register write strobe |
| res_idx | input | IDXW | Slot whose result register is accessed |
| seq_start | input | 1 | Converter sequence start pulse |
| slot_done | input | 1 | Converter slot conversion done pulse |
| slot_idx | input | IDXW | Slot that finished |
| cmp_hit | input | 1 | Compare succeeded for the finished slot |
| seq_done | input | 1 | Converter sequence done pulse |
| slot_flags | output | NSLOT | Per-slot completion flags |
| seq_flag | output | 1 | Sequence-complete flag |
| seq_busy | output | 1 | State machine is in RUN |
| abort_o | output | 1 | One-cycle sequence abort pulse |
| seq_irq | output | 1 | Sequence-complete interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The bench runs every combination of slot, compare enable, fast-clear setting and clear method (write-one, result read, result write). A design that swaps the read and write rule, or that still honours write-one in fast mode, leaves some flag standing or wipes one that should stay. It also sweeps every compare-enable pattern against both compare outcomes, which catches flags that set on a failed compare and a compare interrupt that ignores its enables. Directed cases cover a set and a clear landing on the same slot in the same cycle (a design with clear priority loses the completion). They also cover `seq_done` arriving together with a control write, pulses arriving while halted, and the relaunch rule for the sequence flag, where a wrong design keeps a stale flag or drops one it should keep.

// File: rtl/cfic_pkg.sv
package cfic_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_HALT = 2'd2
    } seq_st_e;

    localparam int CTRL_W = 3;

    // Bit 2 fast-clear, bit 1 sequence irq enable, bit 0 compare irq enable
    typedef struct packed {
        logic fast;
        logic seq_ie;
        logic cmp_ie;
    } ctrl_t;
endpackage

// File: rtl/cfic_seq_fsm.sv
module cfic_seq_fsm
    import cfic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic seq_start,
    input  logic seq_done,
    input  logic seq_clr_wr,
    output logic busy,
    output logic accept,
    output logic abort_o,
    output logic seq_flag
);
    seq_st_e state_q, state_d;
    logic    flag_q, flag_d;
    logic    abort_q;
    logic    t_launch, t_finish, t_abort, t_relaunch;

    // Transition decode
    always_comb begin
        t_launch   = 1'b0;
        t_finish   = 1'b0;
        t_abort    = 1'b0;
        t_relaunch = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (seq_start && !ctrl_wr) begin
                    t_launch = 1'b1;
                    state_d  = SQ_RUN;
                end
            end
            SQ_RUN: begin
                if (ctrl_wr) begin
                    t_abort = 1'b1;
                    state_d = SQ_HALT;
                end else if (seq_done) begin
                    t_finish = 1'b1;
                    state_d  = SQ_IDLE;
                end
            end
            SQ_HALT: begin
                if (seq_start && !ctrl_wr) begin
                    t_relaunch = 1'b1;
                    state_d    = SQ_RUN;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // Sequence flag next value: set beats clear
    always_comb begin
        flag_d = flag_q;
        if (t_finish)
            flag_d = 1'b1;
        else if (seq_clr_wr || t_relaunch)
            flag_d = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            abort_q <= ctrl_wr;
        end
    end

    assign busy     = (state_q == SQ_RUN);
    assign accept   = (state_q == SQ_RUN) && !ctrl_wr;
    assign abort_o  = abort_q;
    assign seq_flag = flag_q;
endmodule

// File: rtl/cfic_slot_flags.sv
module cfic_slot_flags #(
    parameter int NSLOT = 8,
    parameter int IDXW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             slot_done,
    input  logic [IDXW-1:0]  slot_idx,
    input  logic             cmp_hit,
    input  logic [NSLOT-1:0] cmpen,
    input  logic             fast,
    input  logic             clr_wr,
    input  logic [NSLOT-1:0] clr_data,
    input  logic             res_rd,
    input  logic             res_wr,
    input  logic [IDXW-1:0]  res_idx,
    output logic [NSLOT-1:0] flags
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic sel_done, sel_res, set_i, clr_fast, clr_norm, clr_i, q;

        assign sel_done = slot_done && (slot_idx == IDXW'(i));
        assign sel_res  = (res_idx == IDXW'(i));
        assign set_i    = accept && sel_done && (!cmpen[i] || cmp_hit);
        assign clr_fast = sel_res && (cmpen[i] ? res_wr : res_rd);
        assign clr_norm = clr_wr && clr_data[i];
        assign clr_i    = fast ? clr_fast : clr_norm;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= 1'b0;
            else if (set_i)
                q <= 1'b1;
            else if (clr_i)
                q <= 1'b0;
        end

        assign flags[i] = q;
    end
endmodule

// File: rtl/cfic_irq.sv
module cfic_irq #(
    parameter int NSLOT = 8
) (
    input  logic [NSLOT-1:0] flags,
    input  logic [NSLOT-1:0] cmpen,
    input  logic             seq_flag,
    input  logic             seq_ie,
    input  logic             cmp_ie,
    output logic             seq_irq,
    output logic             cmp_irq
);
    assign seq_irq = seq_ie && seq_flag;
    assign cmp_irq = cmp_ie && (|(flags & cmpen));
endmodule

// File: rtl/cfic_top.sv
module cfic_top
    import cfic_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              cmpen_wr,
    input  logic [NSLOT-1:0]  cmpen_wdata,
    output logic [NSLOT-1:0]  cmpen_rdata,
    input  logic              flag_clr_wr,
    input  logic [NSLOT-1:0]  flag_clr_data,
    input  logic              seq_clr_wr,
    input  logic              res_rd,
    input  logic              res_wr,
    input  logic [IDXW-1:0]   res_idx,
    input  logic              seq_start,
    input  logic              slot_done,
    input  logic [IDXW-1:0]   slot_idx,
    input  logic              cmp_hit,
    input  logic              seq_done,
    output logic [NSLOT-1:0]  slot_flags,
    output logic              seq_flag,
    output logic              seq_busy,
    output logic              abort_o,
    output logic              seq_irq,
    output logic              cmp_irq
);
    ctrl_t            ctrl_q;
    logic [NSLOT-1:0] cmpen_q;
    logic             accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmpen_q <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= ctrl_t'(ctrl_wdata);
            if (cmpen_wr)
                cmpen_q <= cmpen_wdata;
        end
    end

    assign ctrl_rdata  = ctrl_q;
    assign cmpen_rdata = cmpen_q;

    cfic_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .seq_start  (seq_start),
        .seq_done   (seq_done),
        .seq_clr_wr (seq_clr_wr),
        .busy       (seq_busy),
        .accept     (accept),
        .abort_o    (abort_o),
        .seq_flag   (seq_flag)
    );

    cfic_slot_flags #(.NSLOT(NSLOT), .IDXW(IDXW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .slot_done (slot_done),
        .slot_idx  (slot_idx),
        .cmp_hit   (cmp_hit),
        .cmpen     (cmpen_q),
        .fast      (ctrl_q.fast),
        .clr_wr    (flag_clr_wr),
        .clr_data  (flag_clr_data),
        .res_rd    (res_rd),
        .res_wr    (res_wr),
        .res_idx   (res_idx),
        .flags     (slot_flags)
    );

    cfic_irq #(.NSLOT(NSLOT)) u_irq (
        .flags    (slot_flags),
        .cmpen    (cmpen_q),
        .seq_flag (seq_flag),
        .seq_ie   (ctrl_q.seq_ie),
        .cmp_ie   (ctrl_q.cmp_ie),
        .seq_irq  (seq_irq),
        .cmp_irq  (cmp_irq)
    );
endmodule

// File: rtl/cfic_chk.sv
module cfic_chk #(
    parameter int NSLOT = 8,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [2:0]       ctrl_rdata,
    input logic [NSLOT-1:0] cmpen_rdata,
    input logic             flag_clr_wr,
    input logic             slot_done,
    input logic [IDXW-1:0]  slot_idx,
    input logic             cmp_hit,
    input logic [NSLOT-1:0] slot_flags,
    input logic             seq_flag,
    input logic             seq_busy,
    input logic             abort_o,
    input logic             seq_irq,
    input logic             cmp_irq
);
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> abort_o && !seq_busy); // R2
    AST_ABORT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(ctrl_wr)); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_done && seq_busy && !ctrl_wr && (32'(slot_idx) < NSLOT) &&
         (!cmpen_rdata[slot_idx] || cmp_hit)) |=> slot_flags[$past(slot_idx)]); // R7
    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[2] && !flag_clr_wr && !slot_done) |=> slot_flags == $past(slot_flags)); // R4
    AST_SEQ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq |-> seq_flag && ctrl_rdata[1]); // R9
    AST_CMP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> ctrl_rdata[0] && ((slot_flags & cmpen_rdata) != '0)); // R10
    AST_IDLE_NO_SEQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |=> !$rose(seq_flag)); // R11
endmodule

bind cfic_top cfic_chk #(.NSLOT(NSLOT)) u_chk (.*);

// File: tb/sim_cfic_top.sv
module sim_cfic_top;
    localparam int  NS   = 4;
    localparam int  IW   = 2;
    localparam time TCLK = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 0, cmpen_wr = 0, flag_clr_wr = 0, seq_clr_wr = 0;
    logic [2:0]    ctrl_wdata = '0, ctrl_rdata;
    logic [NS-1:0] cmpen_wdata = '0, cmpen_rdata, flag_clr_data = '0, slot_flags;
    logic          res_rd = 0, res_wr = 0, seq_start = 0, slot_done = 0, cmp_hit = 0, seq_done = 0;
    logic [IW-1:0] res_idx = '0, slot_idx = '0;
    logic          seq_flag, seq_busy, abort_o, seq_irq, cmp_irq;
    int            n_run = 0, n_fail = 0, cyc = 0;

    always #(TCLK/2) clk = ~clk;

    cfic_top #(.NSLOT(NS)) u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [2:0] v);
        ctrl_wr = 1; ctrl_wdata = v; tick(); ctrl_wr = 0;
    endtask

    task automatic wr_cmpen(logic [NS-1:0] v);
        cmpen_wr = 1; cmpen_wdata = v; tick(); cmpen_wr = 0;
    endtask

    task automatic start_seq();
        seq_start = 1; tick(); seq_start = 0;
    endtask

    task automatic set_slot(int i, logic hit);
        slot_done = 1; slot_idx = IW'(i); cmp_hit = hit; tick();
        slot_done = 0; cmp_hit = 0;
    endtask

    // m: 0 write-one-to-clear, 1 result read, 2 result write
    task automatic clear_by(int m, int i);
        res_idx = IW'(i);
        if (m == 0) begin flag_clr_wr = 1; flag_clr_data = NS'(1) << i; end
        if (m == 1) res_rd = 1;
        if (m == 2) res_wr = 1;
        tick();
        flag_clr_wr = 0; flag_clr_data = '0; res_rd = 0; res_wr = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl reset", 32'(ctrl_rdata), 0);
        check("R1 flags reset", 32'(slot_flags), 0);
        check("R8 seq flag reset", 32'(seq_flag), 0);
        check("R2 abort reset", 32'(abort_o), 0);
        rst_n = 1;
        tick();

        // R1 / R2 control write and abort pulse
        wr_ctrl(3'b101);
        check("R1 ctrl readback", 32'(ctrl_rdata), 32'h5);
        check("R2 abort pulse", 32'(abort_o), 1);
        tick();
        check("R2 abort one cycle", 32'(abort_o), 0);
        start_seq();
        check("R2 running", 32'(seq_busy), 1);
        wr_ctrl(3'b000);
        check("R2 halted", 32'(seq_busy), 0);
        check("R1 ctrl readback zero", 32'(ctrl_rdata), 0);

        // R4 R5 R6 clear sweep
        for (int f = 0; f < 2; f++) begin
            wr_ctrl(3'(f << 2));
            for (int cm = 0; cm < 2; cm++) begin
                wr_cmpen(cm ? '1 : '0);
                for (int i = 0; i < NS; i++) begin
                    for (int m = 0; m < 3; m++) begin
                        int good;
                        logic expf;
                        good = f ? (cm ? 2 : 1) : 0;
                        start_seq();
                        set_slot(i, 1'b1);
                        check("R3 set before clear", 32'(slot_flags[i]), 1);
                        clear_by(m, i);
                        expf = (m == good) ? 1'b0 : 1'b1;
                        if (f == 0) check("R4 normal clear", 32'(slot_flags[i]), 32'(expf));
                        else if (cm == 0) check("R5 fast clear by read", 32'(slot_flags[i]), 32'(expf));
                        else check("R6 fast clear by write", 32'(slot_flags[i]), 32'(expf));
                        if (expf) clear_by(good, i);
                    end
                end
            end
        end

        // R3 R10 set sweep over all compare-enable patterns
        wr_ctrl(3'b001);
        for (int p = 0; p < (1 << NS); p++) begin
            wr_cmpen(NS'(p));
            for (int i = 0; i < NS; i++) begin
                for (int h = 0; h < 2; h++) begin
                    logic expf;
                    flag_clr_wr = 1; flag_clr_data = '1; tick(); flag_clr_wr = 0; flag_clr_data = '0;
                    start_seq();
                    set_slot(i, h[0]);
                    expf = (!p[i]) || (h == 1);
                    check("R3 set rule", 32'(slot_flags), expf ? (32'(1) << i) : 0);
                    check("R10 cmp irq", 32'(cmp_irq), 32'(expf && p[i]));
                end
            end
        end
        wr_ctrl(3'b000);
        check("R10 cmp irq off", 32'(cmp_irq), 0);
        flag_clr_wr = 1; flag_clr_data = '1; tick(); flag_clr_wr = 0; flag_clr_data = '0;
        wr_cmpen('0);

        // R7 set and clear on the same slot in one cycle
        start_seq();
        slot_done = 1; slot_idx = 2'd1; flag_clr_wr = 1; flag_clr_data = 4'b0010;
        tick();
        slot_done = 0; flag_clr_wr = 0; flag_clr_data = '0;
        check("R7 set wins", 32'(slot_flags), 32'h2);

        // R11 pulses while halted and idle are dropped
        wr_ctrl(3'b000);
        set_slot(3, 1'b1);
        check("R11 halted slot ignored", 32'(slot_flags), 32'h2);
        seq_done = 1; tick(); seq_done = 0;
        check("R11 halted seq ignored", 32'(seq_flag), 0);

        // R8 R9 sequence flag and interrupt
        wr_ctrl(3'b010);
        start_seq();
        seq_done = 1; tick(); seq_done = 0;
        check("R8 seq flag set", 32'(seq_flag), 1);
        check("R8 back to idle", 32'(seq_busy), 0);
        check("R9 seq irq on", 32'(seq_irq), 1);
        seq_done = 1; slot_done = 1; slot_idx = 2'd0; tick(); seq_done = 0; slot_done = 0;
        check("R11 idle slot ignored", 32'(slot_flags), 32'h2);
        seq_clr_wr = 1; tick(); seq_clr_wr = 0;
        check("R8 seq flag cleared", 32'(seq_flag), 0);
        check("R9 seq irq off", 32'(seq_irq), 0);
        start_seq();
        seq_done = 1; tick(); seq_done = 0;
        start_seq();
        check("R8 launch keeps flag", 32'(seq_flag), 1);
        wr_ctrl(3'b000);
        check("R9 irq masked", 32'(seq_irq), 0);
        check("R8 abort keeps flag", 32'(seq_flag), 1);
        start_seq();
        check("R8 relaunch clears flag", 32'(seq_flag), 0);
        // R2 seq_done together with a control write is dropped
        ctrl_wr = 1; ctrl_wdata = 3'b010; seq_done = 1; tick(); ctrl_wr = 0; seq_done = 0;
        check("R2 done dropped on abort", 32'(seq_flag), 0);
        check("R2 abort again", 32'(abort_o), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule